// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block is the timing core of a master for an open-drain single-wire bus with a pull-up. It counts microseconds from a tick derived from the system clock. It produces three kinds of bus cycle: a reset-and-presence cycle, a single bit slot, and a byte made of eight bit slots. The bus is never driven high. The block only asserts an enable for the pulldown transistor, and an optional enable for a strong pullup that can feed parasite-powered devices.

A host places an operation code, a data byte and a pullup request on the command inputs and pulses `cmd_start`. The block raises `busy` for the whole cycle. When the cycle ends it pulses `done` for one clock, and its result outputs then hold the presence status, the bus-short status, the sampled bit or the assembled byte. Reading is done by writing ones: each slot releases the bus after its short start pulse, and a device answers by holding the bus low. Reading a byte is therefore the byte operation with data 0xFF. The bus input passes through a synchronizer before it is sampled.

Top module: `owm_slot_engine`

## Requirements
- R1: A reset operation (`cmd_op` = 2'b00) holds `bus_drive_low` high for RST_LOW_US microseconds (default 480). The bus is then released, and `busy` stays high for RST_LOW_US + RST_PRES_US + RST_TAIL_US microseconds in total (default 960).
- R2: `no_presence` is set to the synchronized bus level sampled RST_PRES_US (default 64) microseconds after the reset low ends. A high level there reads as 1, meaning no device answered.
- R3: `bus_short` is set to 1 when the bus is low at the second sample, RST_TAIL_US (default 416) microseconds after the presence sample, and to 0 otherwise.
- R4: Every bit slot drives the bus low for SLOT_INIT_US (default 2) microseconds when it sends a 1, and for SLOT_LEN_US (default 60) microseconds when it sends a 0. A recovery gap of RECOV_US (default 10) microseconds follows each slot, so a slot lasts SLOT_LEN_US + RECOV_US microseconds.
- R5: The bus is sampled SLOT_SAMPLE_US (default 15) microseconds after the slot starts. The returned bit is the sent bit ANDed with that sample, so a low sample forces a 0. A bit operation (`cmd_op` = 2'b01) sends `cmd_data[0]` and returns the result on `rx_bit`.
- R6: A byte operation (`cmd_op` = 2'b10) runs DATA_W slots and sends `cmd_data` least significant bit first. Each returned bit enters at the top of a shift register, so `rx_data` then holds the returned bits in their sent positions. With data 0xFF the operation is a byte read.
- R7: When `cmd_spu` is 1 on a byte operation, `spu_en` rises at the end of the last slot's 60 us window, RECOV_US before `done`. It then stays high until `spu_clear` or the next accepted start. A bit operation never raises it, and it is never high while `bus_drive_low` is high.
- R8: `cmd_start` is accepted only while `busy` is low. `done` is a one-cycle pulse in the cycle in which `busy` has just fallen. A start pulse while busy changes neither the running operation nor its result, and adds no extra `done`.
- R9: After reset `busy`, `done`, `bus_drive_low` and `spu_en` are all 0.
- R10: A start with `cmd_op` = 2'b11 is ignored: `busy` stays low and no `done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse for the operation on `cmd_op` |
| cmd_op | input | 2 | 00 reset, 01 bit, 10 byte, 11 no operation |
| cmd_data | input | DATA_W | Data to send (bit 0 for a bit operation) |
| cmd_spu | input | 1 | Request the strong pullup after the byte |
| spu_clear | input | 1 | Turn the strong pullup off |
| bus_in | input | 1 | Raw bus level (asynchronous) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | DATA_W | Assembled byte |
| rx_bit | output | 1 | Most recently sampled slot bit |
| no_presence | output | 1 | No device answered the last reset |
| bus_short | output | 1 | Bus was still low at the end of the last reset |
| bus_drive_low | output | 1 | Output enable of the bus pulldown |
| spu_en | output | 1 | Strong pullup enable |

## Verification
The embedded properties assume that `spu_clear` and the command inputs are synchronous to `clk`, and that the timing parameters are nonzero and properly ordered. They rely on the elaboration checks for the parameter ordering. The bench changes every input on the falling clock edge. Its device model only ever pulls the bus low, and it reacts only to edges of `bus_drive_low`, so the bus level never depends on anything but the master's output and bounded device pulses. The extra start pulse used to test the ignore rule is a clean one-cycle pulse in the middle of a byte, so the properties about accept, busy and done see legal input.

// File: rtl/owm_pkg.sv
`timescale 1ns/1ps
package owm_pkg;

   typedef enum logic [1:0] {
      OP_RESET = 2'b00,
      OP_BIT   = 2'b01,
      OP_BYTE  = 2'b10,
      OP_NONE  = 2'b11
   } owm_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RST_LOW,
      ST_RST_PRES,
      ST_RST_TAIL,
      ST_SL_LOW,
      ST_SL_PRE,
      ST_SL_POST,
      ST_SL_REC
   } owm_state_e;

   function automatic int unsigned owm_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/owm_tick_gen.sv
`timescale 1ns/1ps
module owm_tick_gen #(
   parameter int unsigned DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("owm_tick_gen: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || cnt == CW'(DIV - 1))
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == CW'(DIV - 1));

   // R4
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/owm_bus_sync.sv
`timescale 1ns/1ps
module owm_bus_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("owm_bus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stg <= '1;
      else
         stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/owm_slot_fsm.sv
`timescale 1ns/1ps
module owm_slot_fsm
   import owm_pkg::*;
#(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned RST_LOW_US     = 480,
   parameter int unsigned RST_PRES_US    = 64,
   parameter int unsigned RST_TAIL_US    = 416,
   parameter int unsigned SLOT_INIT_US   = 2,
   parameter int unsigned SLOT_SAMPLE_US = 15,
   parameter int unsigned SLOT_LEN_US    = 60,
   parameter int unsigned RECOV_US       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_s,
   input  logic              cmd_start,
   input  logic [1:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              cmd_spu,
   input  logic              spu_clear,
   output logic              tick_restart,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit,
   output logic              no_presence,
   output logic              bus_short,
   output logic              drive_low,
   output logic              spu_en
);
   localparam int unsigned PRE_US  = SLOT_SAMPLE_US - SLOT_INIT_US;
   localparam int unsigned POST_US = SLOT_LEN_US - SLOT_SAMPLE_US;
   localparam int unsigned MAX_US  = owm_max(owm_max(owm_max(RST_LOW_US, RST_PRES_US),
                                             owm_max(RST_TAIL_US, SLOT_LEN_US)), RECOV_US);
   localparam int unsigned CW      = $clog2(MAX_US + 1);
   localparam int unsigned BCW     = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("owm_slot_fsm: DATA_W must be at least 2");
      end
      if (SLOT_INIT_US < 1 || SLOT_SAMPLE_US <= SLOT_INIT_US || SLOT_LEN_US <= SLOT_SAMPLE_US) begin : g_bad_slot
         $error("owm_slot_fsm: slot timing must satisfy 0 < INIT < SAMPLE < LEN");
      end
      if (RECOV_US < 1 || RST_LOW_US < 1 || RST_PRES_US < 1 || RST_TAIL_US < 1) begin : g_bad_rst
         $error("owm_slot_fsm: reset and recovery times must be nonzero");
      end
   endgenerate

   owm_state_e        state;
   logic [CW-1:0]     us_cnt;
   logic [CW-1:0]     dur;
   logic              phase_end;
   logic [DATA_W-1:0] sr;
   logic              slot_bit;
   logic [BCW-1:0]    bits_left;
   logic              spu_req;
   owm_op_e           op;

   assign op           = owm_op_e'(cmd_op);
   assign busy         = (state != ST_IDLE);
   assign tick_restart = (state == ST_IDLE) && cmd_start;
   assign rx_data      = sr;

   always_comb begin
      unique case (state)
         ST_RST_LOW:  dur = CW'(RST_LOW_US);
         ST_RST_PRES: dur = CW'(RST_PRES_US);
         ST_RST_TAIL: dur = CW'(RST_TAIL_US);
         ST_SL_LOW:   dur = CW'(SLOT_INIT_US);
         ST_SL_PRE:   dur = CW'(PRE_US);
         ST_SL_POST:  dur = CW'(POST_US);
         ST_SL_REC:   dur = CW'(RECOV_US);
         default:     dur = CW'(1);
      endcase
   end

   assign phase_end = tick && (us_cnt == dur - 1'b1);

   always_comb begin
      unique case (state)
         ST_RST_LOW, ST_SL_LOW:  drive_low = 1'b1;
         ST_SL_PRE, ST_SL_POST:  drive_low = !slot_bit;
         default:                drive_low = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         us_cnt      <= '0;
         sr          <= '0;
         slot_bit    <= 1'b0;
         bits_left   <= '0;
         spu_req     <= 1'b0;
         spu_en      <= 1'b0;
         done        <= 1'b0;
         rx_bit      <= 1'b0;
         no_presence <= 1'b0;
         bus_short   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (spu_clear)
            spu_en <= 1'b0;
         if (state == ST_IDLE) begin
            if (cmd_start && op != OP_NONE) begin
               spu_en  <= 1'b0;
               us_cnt  <= '0;
               spu_req <= cmd_spu && (op == OP_BYTE);
               sr      <= cmd_data;
               if (op == OP_RESET) begin
                  state <= ST_RST_LOW;
               end else begin
                  state     <= ST_SL_LOW;
                  slot_bit  <= cmd_data[0];
                  bits_left <= (op == OP_BYTE) ? BCW'(DATA_W - 1) : '0;
               end
            end
         end else if (phase_end) begin
            us_cnt <= '0;
            unique case (state)
               ST_RST_LOW:  state <= ST_RST_PRES;
               ST_RST_PRES: begin
                  no_presence <= bus_s;
                  state       <= ST_RST_TAIL;
               end
               ST_RST_TAIL: begin
                  bus_short <= !bus_s;
                  state     <= ST_IDLE;
                  done      <= 1'b1;
               end
               ST_SL_LOW:   state <= ST_SL_PRE;
               ST_SL_PRE: begin
                  rx_bit <= slot_bit & bus_s;
                  state  <= ST_SL_POST;
               end
               ST_SL_POST: begin
                  sr <= {rx_bit, sr[DATA_W-1:1]};
                  if (bits_left == '0 && spu_req)
                     spu_en <= 1'b1;
                  state <= ST_SL_REC;
               end
               ST_SL_REC: begin
                  if (bits_left == '0) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     bits_left <= bits_left - 1'b1;
                     slot_bit  <= sr[0];
                     state     <= ST_SL_LOW;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end else if (tick) begin
            us_cnt <= us_cnt + 1'b1;
         end
      end
   end

   // R7
   spu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(spu_en && drive_low));

   // R7
   spu_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spu_en) |-> (state == ST_SL_REC && bits_left == '0));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R4
   phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (us_cnt < dur));

endmodule

// File: rtl/owm_slot_engine.sv
`timescale 1ns/1ps
module owm_slot_engine #(
   parameter int unsigned CLK_PER_US     = 50,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned RST_LOW_US     = 480,
   parameter int unsigned RST_PRES_US    = 64,
   parameter int unsigned RST_TAIL_US    = 416,
   parameter int unsigned SLOT_INIT_US   = 2,
   parameter int unsigned SLOT_SAMPLE_US = 15,
   parameter int unsigned SLOT_LEN_US    = 60,
   parameter int unsigned RECOV_US       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [1:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              cmd_spu,
   input  logic              spu_clear,
   input  logic              bus_in,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit,
   output logic              no_presence,
   output logic              bus_short,
   output logic              bus_drive_low,
   output logic              spu_en
);
   logic tick;
   logic tick_restart;
   logic bus_s;

   owm_tick_gen #(.DIV(CLK_PER_US)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (tick_restart),
      .tick    (tick)
   );

   owm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_in),
      .q     (bus_s)
   );

   owm_slot_fsm #(
      .DATA_W         (DATA_W),
      .RST_LOW_US     (RST_LOW_US),
      .RST_PRES_US    (RST_PRES_US),
      .RST_TAIL_US    (RST_TAIL_US),
      .SLOT_INIT_US   (SLOT_INIT_US),
      .SLOT_SAMPLE_US (SLOT_SAMPLE_US),
      .SLOT_LEN_US    (SLOT_LEN_US),
      .RECOV_US       (RECOV_US)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .bus_s        (bus_s),
      .cmd_start    (cmd_start),
      .cmd_op       (cmd_op),
      .cmd_data     (cmd_data),
      .cmd_spu      (cmd_spu),
      .spu_clear    (spu_clear),
      .tick_restart (tick_restart),
      .busy         (busy),
      .done         (done),
      .rx_data      (rx_data),
      .rx_bit       (rx_bit),
      .no_presence  (no_presence),
      .bus_short    (bus_short),
      .drive_low    (bus_drive_low),
      .spu_en       (spu_en)
   );

endmodule

// File: tb/test_owm_slot_engine.sv
`timescale 1ns/1ps
module test_owm_slot_engine;
   localparam int US       = 5;
   localparam int RST_LOW  = 480;
   localparam int RST_PRES = 64;
   localparam int RST_TAIL = 416;
   localparam int S_INIT   = 2;
   localparam int S_LEN    = 60;
   localparam int RECOV    = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_start = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [7:0] cmd_data = 8'h00;
   logic       cmd_spu = 1'b0;
   logic       spu_clear = 1'b0;
   logic       bus_in;
   logic       busy, done, rx_bit, no_presence, bus_short, bus_drive_low, spu_en;
   logic [7:0] rx_data;
   logic       dev_pull = 1'b0;

   always #10 clk = ~clk;

   assign bus_in = !(bus_drive_low || dev_pull);

   owm_slot_engine #(.CLK_PER_US(US)) i_owm_slot_engine (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .cmd_spu(cmd_spu), .spu_clear(spu_clear),
      .bus_in(bus_in), .busy(busy), .done(done), .rx_data(rx_data),
      .rx_bit(rx_bit), .no_presence(no_presence), .bus_short(bus_short),
      .bus_drive_low(bus_drive_low), .spu_en(spu_en)
   );

   typedef struct {
      int       kind;
      logic [7:0] data;
      logic     bitv;
      logic     np;
      logic     sh;
   } exp_t;

   exp_t exp_q[$];
   int   wq[$];
   bit   resp_q[$];
   int   total = 0, bad = 0;
   int   cyc = 0, done_cnt = 0, overlap = 0;
   int   spu_rise_cyc = 0, done_cyc = 0, last_rst_w = 0;
   int   dev_mode = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // monitor: pops the scoreboard on every done pulse
   initial begin
      logic spu_prev;
      spu_prev = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         if (spu_en && bus_drive_low) overlap++;
         if (spu_en && !spu_prev) spu_rise_cyc = cyc;
         spu_prev = spu_en;
         if (done) begin
            done_cnt++;
            done_cyc = cyc;
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               case (e.kind)
                  0: begin
                     check(no_presence == e.np, "R2", "no_presence", int'(no_presence), int'(e.np));
                     check(bus_short == e.sh, "R3", "bus_short", int'(bus_short), int'(e.sh));
                  end
                  1: check(rx_bit == e.bitv, "R5", "rx_bit", int'(rx_bit), int'(e.bitv));
                  default: check(rx_data == e.data, "R6", "rx_data", int'(rx_data), int'(e.data));
               endcase
            end
         end
      end
   end

   // device model: presence pulse, answers in slots, records low widths
   initial begin
      int  lowcnt, since_rel, slot_t;
      bit  resp_bit;
      lowcnt = 0; since_rel = -1; slot_t = -1; resp_bit = 1'b1;
      forever begin
         @(negedge clk);
         if (bus_drive_low) begin
            if (lowcnt == 0) begin
               resp_bit = (resp_q.size() > 0) ? resp_q.pop_front() : 1'b1;
               slot_t = 0;
            end
            lowcnt++;
         end else if (lowcnt > 0) begin
            if (lowcnt >= 400*US) begin
               since_rel = 0;
               last_rst_w = lowcnt;
            end else begin
               wq.push_back(lowcnt);
            end
            lowcnt = 0;
         end
         if (slot_t >= 0) begin
            slot_t++;
            if (slot_t > 30*US) slot_t = -1;
         end
         if (since_rel >= 0) begin
            since_rel++;
            if (since_rel > 200*US) since_rel = -1;
         end
         dev_pull = (dev_mode == 2) ||
                    (dev_mode == 0 && since_rel >= 20*US && since_rel < 120*US) ||
                    (slot_t >= 0 && !resp_bit);
      end
   end

   task automatic run_op(input logic [1:0] op, input logic [7:0] data,
                         input logic [7:0] resp, input bit spu, input bit poke,
                         input int nslots);
      exp_t e;
      int   lat, exp_lat, d0;
      wq.delete();
      for (int i = 0; i < nslots; i++) resp_q.push_back(resp[i]);
      e.kind = int'(op);
      e.data = data & resp;
      e.bitv = data[0] & resp[0];
      e.np   = (dev_mode == 1);
      e.sh   = (dev_mode == 2);
      exp_q.push_back(e);
      d0 = done_cnt;
      cmd_op = op; cmd_data = data; cmd_spu = spu; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      lat = 0;
      while (busy && lat < 20000) begin
         lat++;
         if (poke && lat == 100) begin
            cmd_start = 1'b1; cmd_op = 2'b00;
         end else begin
            cmd_start = 1'b0;
         end
         @(negedge clk);
      end
      cmd_start = 1'b0;
      exp_lat = (op == 2'b00) ? (RST_LOW + RST_PRES + RST_TAIL) * US
                              : nslots * (S_LEN + RECOV) * US;
      check(lat >= exp_lat - 2 && lat <= exp_lat + 2,
            (op == 2'b00) ? "R1" : "R4", "busy length", lat, exp_lat);
      @(negedge clk);
      check(exp_q.size() == 0, "R8", "result delivered", exp_q.size(), 0);
      check(done_cnt == d0 + 1, "R8", "done count", done_cnt - d0, 1);
      if (op == 2'b00) begin
         check(last_rst_w >= RST_LOW*US - 1 && last_rst_w <= RST_LOW*US + 1,
               "R1", "reset low width", last_rst_w, RST_LOW*US);
      end else begin
         check(wq.size() == nslots, "R4", "slot count", wq.size(), nslots);
         for (int i = 0; i < nslots && i < wq.size(); i++) begin
            int ew;
            ew = data[i] ? S_INIT*US : S_LEN*US;
            check(wq[i] >= ew - 1 && wq[i] <= ew + 1, "R4", "slot low width", wq[i], ew);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(busy == 1'b0, "R9", "busy", int'(busy), 0);
      check(done == 1'b0, "R9", "done", int'(done), 0);
      check(bus_drive_low == 1'b0, "R9", "bus_drive_low", int'(bus_drive_low), 0);
      check(spu_en == 1'b0, "R9", "spu_en", int'(spu_en), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 R2 R3: normal, absent, shorted
      dev_mode = 0; run_op(2'b00, 8'h00, 8'hFF, 1'b0, 1'b0, 0);
      dev_mode = 1; run_op(2'b00, 8'h00, 8'hFF, 1'b0, 1'b0, 0);
      dev_mode = 2; run_op(2'b00, 8'h00, 8'hFF, 1'b0, 1'b0, 0);
      dev_mode = 0; repeat (10) @(negedge clk);

      // R5 single bits
      run_op(2'b01, 8'h01, 8'hFF, 1'b0, 1'b0, 1);
      run_op(2'b01, 8'h00, 8'hFF, 1'b0, 1'b0, 1);
      run_op(2'b01, 8'h01, 8'hFE, 1'b0, 1'b0, 1);

      // R6 byte write and byte read
      run_op(2'b10, 8'hA5, 8'hFF, 1'b0, 1'b0, 8);
      run_op(2'b10, 8'hFF, 8'h3C, 1'b0, 1'b0, 8);

      // R8 start pulse while busy is ignored
      run_op(2'b10, 8'hC3, 8'hF0, 1'b0, 1'b1, 8);

      // R7 strong pullup after the last slot of a byte
      run_op(2'b10, 8'h5A, 8'hFF, 1'b1, 1'b0, 8);
      check(spu_en == 1'b1, "R7", "spu_en after byte", int'(spu_en), 1);
      check(done_cyc - spu_rise_cyc >= RECOV*US - 1 && done_cyc - spu_rise_cyc <= RECOV*US + 1,
            "R7", "pullup lead before done", done_cyc - spu_rise_cyc, RECOV*US);
      repeat (20) @(negedge clk);
      check(spu_en == 1'b1, "R7", "spu_en held", int'(spu_en), 1);
      spu_clear = 1'b1; @(negedge clk); spu_clear = 1'b0;
      check(spu_en == 1'b0, "R7", "spu_en cleared", int'(spu_en), 0);

      // R7 next start turns the pullup off
      run_op(2'b10, 8'hFF, 8'hFF, 1'b1, 1'b0, 8);
      check(spu_en == 1'b1, "R7", "spu_en second byte", int'(spu_en), 1);
      cmd_op = 2'b01; cmd_data = 8'h01; cmd_spu = 1'b0; exp_q.push_back('{1, 8'h00, 1'b1, 1'b0, 1'b0});
      cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
      check(spu_en == 1'b0, "R7", "spu_en off at new start", int'(spu_en), 0);
      while (busy) @(negedge clk);
      @(negedge clk);

      // R7 bit operation never raises the pullup
      run_op(2'b01, 8'h01, 8'hFF, 1'b1, 1'b0, 1);
      check(spu_en == 1'b0, "R7", "spu_en after bit op", int'(spu_en), 0);

      // R10 no-operation code
      begin
         int d0;
         d0 = done_cnt;
         cmd_op = 2'b11; cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
         check(busy == 1'b0, "R10", "busy after op 11", int'(busy), 0);
         repeat (20) @(negedge clk);
         check(done_cnt == d0, "R10", "done after op 11", done_cnt - d0, 0);
      end

      check(overlap == 0, "R7", "pullup while driving low", overlap, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule